// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one programmed mode word and a start request into the column address stream of a single SDRAM burst. Software or an init engine loads the 12-bit mode word with a load strobe. A controller then pulses start with an 8-bit starting column and a read/write flag. From the next cycle on, the block emits one column per clock, flagged valid, and marks the final beat. The column order follows the programmed length and ordering. Sequential bursts count upward and wrap inside an aligned block. Interleaved bursts XOR the beat index into the low bits. A full-page burst walks all 256 columns of the row.

For reads, the block raises a data-valid strobe a fixed number of clocks after each issued column. That number is the programmed CAS latency. A terminate input cuts the column stream short, but strobes still appear for read columns that were already issued. A sticky error output flags a mode word that uses reserved or non-standard codes. While the error is set, start requests are refused.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, col_valid, col_last and rd_valid are 0 and mode_err is 0. The mode in force is length 1, sequential, CAS latency 2, and write-single off (word 12'h020).
- R2: Mode bits [2:0] select the burst length: 000=1, 001=2, 010=4, 011=8, 111=256. A burst shows exactly that many beats with col_valid=1, col_last=1 on the final beat only, and col_valid=0 afterwards.
- R3: Sequential bursts (bit [3]=0) of length 2, 4 or 8 keep the upper column bits of the start. The low 1, 2 or 3 bits count up from the start value and wrap modulo the length.
- R4: Interleaved bursts (bit [3]=1) of length 2, 4 or 8 keep the upper bits of the start. On beat k the low bits equal the start low bits XOR k.
- R5: A 256-beat burst, allowed only with bit [3]=0, emits (start+k) mod 256 on beat k.
- R6: A length-1 burst emits only the start column, whatever the value of bit [3].
- R7: When bit [9]=1, a write burst (start_wr=1) emits only the start column. Read bursts keep the programmed length.
- R8: Mode bits [6:4] select the CAS latency: 010=2, 011=3. For each column shown with col_valid during a read burst, rd_valid is 1 exactly that many cycles later. Write bursts never raise rd_valid.
- R9: A column shown while term=1 is the last column of that burst: col_valid is 0 in the next cycle unless a new start is accepted. The rd_valid strobes of read columns already issued still appear.
- R10: The mode word is reserved or non-standard when any of these holds: its length code is not listed in R2, code 111 is combined with bit [3]=1, its latency code is not listed in R8, bits [8:7] are non-zero, or bits [11:10] are non-zero. A load of such a word sets mode_err, and a load of a valid word clears it. Between loads mode_err holds its value, and while it is 1 every start is ignored.
- R11: A start is accepted when col_valid=0, when the current column is the final one, or when term=1. Beat 0 then appears in the next cycle. Starts at any other time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Latch mode_word this cycle |
| mode_word | input | 12 | Mode word to program |
| start | input | 1 | Burst start request |
| start_col | input | 8 | Starting column of the burst |
| start_wr | input | 1 | 1 = write burst, 0 = read burst |
| term | input | 1 | Terminate the running burst after this column |
| col_valid | output | 1 | col_addr carries a burst column |
| col_addr | output | 8 | Column address of the current beat |
| col_last | output | 1 | Current beat is the burst's final one |
| rd_valid | output | 1 | Read data valid, CAS latency after a read column |
| mode_err | output | 1 | Sticky flag for a reserved mode word |

## Verification
Two functions can fall in the same cycle. One is the start of a new burst, or a terminate. The other is the delayed read-strobe tail of the burst before it. The bench provokes this in three ways: a start on the final beat, a terminate in mid-burst, and a terminate paired with a start. It then checks that the new burst's beat 0 appears in the very next cycle while rd_valid still fires exactly the CAS latency after every read column that was issued. The strobe expectations are kept per cycle in a table that the bench fills from the columns it has observed. Because of this, strobes of overlapping bursts are judged independently of which burst produced them.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  localparam int MODE_W = 12;
  localparam int CL_W   = 2;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic [2:0]      len_code;
    logic            ilv;
    logic [CL_W-1:0] cl;
    logic            wr_single;
  } mode_t;

  function automatic logic word_bad(input logic [MODE_W-1:0] w);
    logic len_ok;
    logic cl_ok;
    len_ok = (w[2:0] == LEN_1) || (w[2:0] == LEN_2) || (w[2:0] == LEN_4) ||
             (w[2:0] == LEN_8) || ((w[2:0] == LEN_PAGE) && !w[3]);
    cl_ok  = (w[6:4] == 3'b010) || (w[6:4] == 3'b011);
    return !(len_ok && cl_ok && (w[8:7] == 2'b00) && (w[11:10] == 2'b00));
  endfunction

endpackage

// File: rtl/sbs_mode_reg.sv
module sbs_mode_reg
  import sbs_pkg::*;
#(
  parameter logic [MODE_W-1:0] RST_WORD = 12'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output mode_t             mode,
  output logic              err
);

  logic [MODE_W-1:0] word_q, word_d;
  logic              err_q, err_d;

  always_comb begin
    word_d = word_q;
    err_d  = err_q;
    if (load) begin
      word_d = word;
      err_d  = word_bad(word);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= RST_WORD;
      err_q  <= 1'b0;
    end else if (load) begin
      word_q <= word_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    mode.len_code  = word_q[2:0];
    mode.ilv       = word_q[3];
    mode.cl        = word_q[5:4];
    mode.wr_single = word_q[9];
  end

  assign err = err_q;

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(err));

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && word[11:7] == 5'b0 && word[6:4] == 3'b010 && word[2:0] == 3'b001) |=> !err);

endmodule

// File: rtl/sbs_col_gen.sv
module sbs_col_gen
  import sbs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             term,
  input  mode_t            mode,
  input  logic             mode_err,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             rd_issue,
  output logic [CL_W-1:0]  cl_cur
);

  localparam int CNT_W = COL_W + 1;

  logic             act_q, act_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] beat_q, beat_d;
  logic [CNT_W-1:0] lidx_q, lidx_d;
  logic             ilv_q, ilv_d;
  logic             wr_q, wr_d;
  logic [CL_W-1:0]  cl_q, cl_d;

  logic             at_last;
  logic             accept;
  logic             upd;
  logic [CNT_W-1:0] len_m1;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] low;

  // length minus one of a new burst; doubles as the wrap mask
  always_comb begin
    unique case (mode.len_code)
      LEN_2:    len_m1 = CNT_W'(1);
      LEN_4:    len_m1 = CNT_W'(3);
      LEN_8:    len_m1 = CNT_W'(7);
      LEN_PAGE: len_m1 = CNT_W'((1 << COL_W) - 1);
      default:  len_m1 = '0;
    endcase
    if (start_wr && mode.wr_single) len_m1 = '0;
  end

  assign at_last = act_q && (beat_q == lidx_q);
  assign accept  = start && !mode_err && (!act_q || at_last || term);
  assign upd     = accept || act_q;

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    beat_d = beat_q;
    lidx_d = lidx_q;
    ilv_d  = ilv_q;
    wr_d   = wr_q;
    cl_d   = cl_q;
    if (accept) begin
      act_d  = 1'b1;
      base_d = start_col;
      beat_d = '0;
      lidx_d = len_m1;
      ilv_d  = mode.ilv;
      wr_d   = start_wr;
      cl_d   = mode.cl;
    end else if (act_q && (at_last || term)) begin
      act_d  = 1'b0;
    end else if (act_q) begin
      beat_d = beat_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      lidx_q <= '0;
      ilv_q  <= 1'b0;
      wr_q   <= 1'b0;
      cl_q   <= '0;
    end else if (upd) begin
      act_q  <= act_d;
      base_q <= base_d;
      beat_q <= beat_d;
      lidx_q <= lidx_d;
      ilv_q  <= ilv_d;
      wr_q   <= wr_d;
      cl_q   <= cl_d;
    end
  end

  assign mask = lidx_q[COL_W-1:0];
  assign low  = ilv_q ? (base_q ^ beat_q[COL_W-1:0]) : (base_q + beat_q[COL_W-1:0]);

  assign col_valid = act_q;
  assign col_last  = at_last;
  assign col_addr  = (base_q & ~mask) | (low & mask);
  assign rd_issue  = act_q && !wr_q;
  assign cl_cur    = cl_q;

  p_last_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  p_term_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && term && !start) |=> !col_valid);

  p_continue_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !term) |=> (col_valid && !$stable(col_addr | {COL_W{mask == '0}})));

  p_err_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_err && !col_valid) |=> !col_valid);

  p_new_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (col_valid && col_addr == $past(start_col)));

endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe
  import sbs_pkg::*;
#(
  parameter int CL_MAX = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [CL_W-1:0] cl,
  output logic            rd_valid
);

  logic [CL_MAX-1:0] v_q, v_d;
  logic [CL_W-1:0]   c_q [CL_MAX];
  logic [CL_W-1:0]   c_d [CL_MAX];
  logic [CL_MAX-1:0] fire;

  always_comb begin
    v_d[0] = issue;
    c_d[0] = cl;
    for (int i = 1; i < CL_MAX; i++) begin
      v_d[i] = v_q[i-1];
      c_d[i] = c_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < CL_MAX; i++) c_q[i] <= '0;
    end else begin
      v_q <= v_d;
      for (int i = 0; i < CL_MAX; i++) c_q[i] <= c_d[i];
    end
  end

  // stage i holds an issue made i+1 cycles ago; fire where that matches its latency
  for (genvar g = 0; g < CL_MAX; g++) begin : g_tap
    assign fire[g] = v_q[g] && (c_q[g] == CL_W'(g + 1));
  end

  assign rd_valid = |fire;

  p_rd_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(issue, 2) || $past(issue, 3)));

  p_one_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int CL_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_wr,
  input  logic              term,
  output logic              col_valid,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_last,
  output logic              rd_valid,
  output logic              mode_err
);

  mode_t           mode;
  logic            rd_issue;
  logic [CL_W-1:0] cl_cur;

  sbs_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mode_load),
    .word  (mode_word),
    .mode  (mode),
    .err   (mode_err)
  );

  sbs_col_gen #(.COL_W(COL_W)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .start_wr  (start_wr),
    .term      (term),
    .mode      (mode),
    .mode_err  (mode_err),
    .col_valid (col_valid),
    .col_addr  (col_addr),
    .col_last  (col_last),
    .rd_issue  (rd_issue),
    .cl_cur    (cl_cur)
  );

  sbs_rd_pipe #(.CL_MAX(CL_MAX)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (rd_issue),
    .cl       (cl_cur),
    .rd_valid (rd_valid)
  );

endmodule

// File: tb/sim_sdram_burst_seq.sv
module sim_sdram_burst_seq;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_load;
  logic [11:0] mode_word;
  logic        start;
  logic [7:0]  start_col;
  logic        start_wr;
  logic        term;
  logic        col_valid;
  logic [7:0]  col_addr;
  logic        col_last;
  logic        rd_valid;
  logic        mode_err;

  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  logic [15:0] exp_rd = '0;
  bit          done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sdram_burst_seq u0 (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .start(start), .start_col(start_col), .start_wr(start_wr), .term(term),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
    .rd_valid(rd_valid), .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // advance one cycle; sample at the falling edge; judge the read strobe
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    chk(rd_valid == exp_rd[cyc % 16], "R8 rd_valid", int'(rd_valid), int'(exp_rd[cyc % 16]));
    exp_rd[cyc % 16] = 1'b0;
  endtask

  function automatic logic [11:0] mk(input int len_code, input int ilv, input int cl, input int b9);
    return 12'((b9 << 9) | (cl << 4) | (ilv << 3) | len_code);
  endfunction

  function automatic bit bad_word(input int w);
    int  lc;
    int  c;
    bit  ok;
    lc = w % 8;
    c  = (w / 16) % 8;
    ok = (lc < 4) || (lc == 7 && ((w / 8) % 2) == 0);
    ok = ok && (c == 2 || c == 3) && ((w / 128) % 4 == 0) && (w / 1024 == 0);
    return !ok;
  endfunction

  function automatic int len_of(input int len_code);
    case (len_code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 256;
    endcase
  endfunction

  function automatic int exp_addr(input int s, input int len, input int ilv, input int k);
    int off;
    if (len == 256) return (s + k) % 256;
    off = s % len;
    if (ilv != 0) off = off ^ k;
    else          off = (off + k) % len;
    return (s - s % len) + off;
  endfunction

  task automatic load(input logic [11:0] w);
    mode_load = 1'b1;
    mode_word = w;
    tick();
    mode_load = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) tick();
  endtask

  // run a whole burst and check each beat; entered and left at a falling edge
  task automatic run_burst(input int s, input int len, input int ilv, input int cl,
                           input int wr, input string req);
    start = 1'b1; start_col = 8'(s); start_wr = wr[0];
    tick();
    start = 1'b0;
    for (int k = 0; k < len; k++) begin
      chk(col_valid && col_addr == 8'(exp_addr(s, len, ilv, k)) && col_last == (k == len - 1),
          req, {col_valid, col_last, col_addr}, {1'b1, k == len - 1, 8'(exp_addr(s, len, ilv, k))});
      if (wr == 0) exp_rd[(cyc + cl) % 16] = 1'b1;
      tick();
    end
    chk(!col_valid, "R2 end of burst", int'(col_valid), 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_load = 1'b0; mode_word = '0; start = 1'b0;
    start_col = '0; start_wr = 1'b0; term = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state and default mode
    chk(!col_valid && !col_last && !rd_valid && !mode_err, "R1 reset outputs",
        {col_valid, col_last, rd_valid, mode_err}, 0);
    run_burst(8'h5a, 1, 0, 2, 0, "R1 default single column");
    drain();

    // R10 exhaustive decode of the error flag
    for (int w = 0; w < 4096; w++) begin
      load(12'(w));
      chk(mode_err == bad_word(w), "R10 mode_err decode", int'(mode_err), int'(bad_word(w)));
    end

    // R10 starts ignored while in error, then recovered
    load(mk(2, 0, 1, 0));
    start = 1'b1; start_col = 8'h10; start_wr = 1'b0;
    tick();
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(!col_valid, "R10 start ignored on error", int'(col_valid), 0);
      tick();
    end
    load(mk(2, 0, 2, 0));
    chk(!mode_err, "R10 error cleared", int'(mode_err), 0);
    run_burst(8'h13, 4, 0, 2, 0, "R10 burst after recovery");
    drain();

    // R2-R8 sweep of every valid length, order, latency, write-single and direction
    for (int li = 0; li < 5; li++) begin
      for (int ilv = 0; ilv < 2; ilv++) begin
        for (int cl = 2; cl < 4; cl++) begin
          for (int b9 = 0; b9 < 2; b9++) begin
            int lc;
            lc = (li == 4) ? 7 : li;
            if (lc == 7 && ilv == 1) continue;
            load(mk(lc, ilv, cl, b9));
            for (int wr = 0; wr < 2; wr++) begin
              for (int si = 0; si < 16; si++) begin
                int len;
                len = (wr == 1 && b9 == 1) ? 1 : len_of(lc);
                run_burst((si * 37 + 3) % 256, len, ilv, cl, wr,
                          (len == 256) ? "R5 page order" :
                          (len == 1) ? ((wr == 1 && b9 == 1) ? "R7 write single" : "R6 single column") :
                          (ilv != 0) ? "R4 interleaved order" : "R3 sequential order");
              end
            end
            drain();
          end
        end
      end
    end

    // R9 terminate mid-burst; strobes of issued reads still arrive
    load(mk(3, 0, 3, 0));
    start = 1'b1; start_col = 8'h25; start_wr = 1'b0;
    tick();
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(col_valid && col_addr == 8'(exp_addr(8'h25, 8, 0, k)), "R9 beat before terminate",
          int'(col_addr), exp_addr(8'h25, 8, 0, k));
      exp_rd[(cyc + 3) % 16] = 1'b1;
      if (k == 3) term = 1'b1;
      tick();
    end
    term = 1'b0;
    chk(!col_valid, "R9 stop after terminate", int'(col_valid), 0);
    drain();

    // R11 start on the final beat while the read tail drains, and terminate plus start
    load(mk(2, 1, 2, 0));
    start = 1'b1; start_col = 8'h41; start_wr = 1'b0;
    tick();
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(col_valid && col_addr == 8'(exp_addr(8'h41, 4, 1, k)), "R11 first burst",
          int'(col_addr), exp_addr(8'h41, 4, 1, k));
      exp_rd[(cyc + 2) % 16] = 1'b1;
      if (k == 3) begin start = 1'b1; start_col = 8'h82; end
      if (k == 1) begin start = 1'b1; start_col = 8'hf0; term = 1'b0; end
      if (k == 2) start = 1'b0;
      tick();
      if (k != 3) start = (k == 0);
    end
    start = 1'b0;
    // k==1 start was ignored (mid-burst), k==3 start was accepted on the final beat
    for (int k = 0; k < 2; k++) begin
      chk(col_valid && col_addr == 8'(exp_addr(8'h82, 4, 1, k)), "R11 back-to-back burst",
          int'(col_addr), exp_addr(8'h82, 4, 1, k));
      exp_rd[(cyc + 2) % 16] = 1'b1;
      if (k == 1) begin term = 1'b1; start = 1'b1; start_col = 8'h07; start_wr = 1'b1; end
      tick();
    end
    term = 1'b0; start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(col_valid && col_addr == 8'(exp_addr(8'h07, 4, 1, k)) && col_last == (k == 3),
          "R11 R9 start with terminate", int'(col_addr), exp_addr(8'h07, 4, 1, k));
      tick();
    end
    chk(!col_valid, "R11 idle after write burst", int'(col_valid), 0);
    drain();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule